// File: doc/BRIEF.md
# Ordered Breakpoint Match Table

This block holds a small table of instruction breakpoints for a CPU debug unit. Each entry pairs a 32-bit program-counter address with a nonzero type code. Software inserts entries, deletes them by exact address and type, and presents a fetch address. For that address the table combinationally returns the type of a matching entry, or zero when no entry matches.

Entries stay packed in the order they were inserted. A new entry always lands in the slot just past the last one in use. A deletion closes the gap by moving every later entry down one slot within a single clock. A lookup compares the address only and reports the earliest matching entry. This gives a deterministic answer when the same address is held with several types.

When translation mode is on, each accepted insert and each successful delete produces a one-cycle invalidate pulse carrying the affected address. A downstream decoded-instruction cache uses it to drop stale work.

Top module: `bp_match_table`

## Requirements
- R1: A synchronous active-high reset empties the table. Afterwards `entry_count` is 0, every lookup returns type 0 with `look_hit` low, and `add_err`, `rem_ok`, `rem_fail` and `inval_valid` are low.
- R2: An insert (`add_req` high) whose type is nonzero and that finds the table not full stores the entry at slot index `entry_count` and increments `entry_count` at that clock edge.
- R3: An insert while `entry_count` equals DEPTH is rejected. `add_err` goes high for one cycle, and the count, the contents and `inval_valid` stay unchanged.
- R4: An insert with type 0 is rejected in the same way as R3, because type 0 means "no breakpoint".
- R5: A delete (`rem_req` high) searches from slot 0 upward for the first entry whose address and type both equal the request. On a match, every later entry moves down one slot, `entry_count` decrements and `rem_ok` pulses, all in one clock.
- R6: A delete with no entry matching both address and type pulses `rem_fail` and changes nothing. This includes an entry that matches the address but not the type.
- R7: A lookup of `look_addr` compares against the slots below `entry_count` only and ignores type. It returns the type of the lowest-indexed match with `look_hit` high, or 0 with `look_hit` low. Slots at or above the count never match, even when they hold old data.
- R8: When `xlat_en` is high during an accepted insert or a successful delete, `inval_valid` is high for the following cycle and `inval_addr` carries the command address. Otherwise no pulse occurs: `xlat_en` low, a rejected insert, a failed delete, or an ignored delete.
- R9: When `add_req` and `rem_req` are both high, the insert is performed and the delete is ignored. Neither `rem_ok` nor `rem_fail` is raised.
- R10: `add_err`, `rem_ok`, `rem_fail` and `inval_valid` are registered. Each is high only in the single cycle after the clock edge that accepted its command, and low in the next cycle unless a new command raises it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation mode; enables invalidate pulses |
| add_req | input | 1 | Insert command strobe |
| rem_req | input | 1 | Delete command strobe |
| cmd_addr | input | 32 | Address for insert/delete |
| cmd_type | input | TW (4) | Type for insert/delete |
| look_addr | input | 32 | Fetch address to look up |
| look_type | output | TW (4) | Type of earliest matching entry, 0 on miss |
| look_hit | output | 1 | Lookup found a match |
| entry_count | output | $clog2(DEPTH+1) (4) | Number of valid entries |
| add_err | output | 1 | Insert was rejected (full or type 0) |
| rem_ok | output | 1 | Delete found and removed an entry |
| rem_fail | output | 1 | Delete found no matching entry |
| inval_valid | output | 1 | Invalidate pulse |
| inval_addr | output | 32 | Address carried by the invalidate pulse |

## Verification
The table walk inserts the same address twice with different types. This tells earliest-entry priority apart from latest-entry priority. Deleting the first of the two then shows the shift-down by making the second type visible.

A delete with a correct address but a wrong type separates the exact-pair search from an address-only search. A delete that leaves a stale copy above the count shows whether lookup honours the valid limit.

Directed tests fill the table to capacity, try an overfull insert, delete from the middle and check the order of the entries that moved, and issue insert and delete together. Reset is checked both at start and after activity.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_REM  = 2'd2
  } op_e;

  // Insert wins over delete when both strobes are high.
  function automatic op_e pick_op(input logic add, input logic rem);
    if (add)      return OP_ADD;
    else if (rem) return OP_REM;
    else          return OP_NONE;
  endfunction
endpackage

// File: rtl/bpt_search.sv
module bpt_search #(
  parameter int DEPTH    = 8,
  parameter int AW       = 32,
  parameter int TW       = 4,
  parameter bit USE_TYPE = 1'b0,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][AW-1:0] slot_addr,
  input  logic [DEPTH-1:0][TW-1:0] slot_type,
  input  logic [CW-1:0]            count,
  input  logic [AW-1:0]            key_addr,
  input  logic [TW-1:0]            key_type,
  output logic                     hit,
  output logic [IW-1:0]            idx
);
  logic [DEPTH-1:0] eq;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
    logic live;
    assign live = CW'(gi) < count;
    if (USE_TYPE) begin : g_pair
      assign eq[gi] = live && (slot_addr[gi] == key_addr) && (slot_type[gi] == key_type);
    end else begin : g_addr
      assign eq[gi] = live && (slot_addr[gi] == key_addr);
    end
  end

  function automatic logic [IW-1:0] lowest_set(input logic [DEPTH-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign hit = |eq;
  assign idx = lowest_set(eq);
endmodule

// File: rtl/bpt_store.sv
module bpt_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int TW    = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  bpt_pkg::op_e             op,
  input  logic [AW-1:0]            wr_addr,
  input  logic [TW-1:0]            wr_type,
  input  logic                     rem_hit,
  input  logic [IW-1:0]            rem_idx,
  output logic [DEPTH-1:0][AW-1:0] slot_addr,
  output logic [DEPTH-1:0][TW-1:0] slot_type,
  output logic [CW-1:0]            count,
  output logic                     add_ok,
  output logic                     add_rej,
  output logic                     rem_do,
  output logic                     rem_miss
);
  import bpt_pkg::*;

  logic                     full;
  logic [IW-1:0]            wr_idx;
  logic [DEPTH-1:0][AW-1:0] nxt_addr;
  logic [DEPTH-1:0][TW-1:0] nxt_type;
  logic [DEPTH-1:0]         shift_en;
  logic [DEPTH-1:0]         load_en;

  assign full     = (count == CW'(DEPTH));
  assign wr_idx   = IW'(count);
  assign add_ok   = (op == OP_ADD) && !full && (wr_type != '0);
  assign add_rej  = (op == OP_ADD) && (full || (wr_type == '0));
  assign rem_do   = (op == OP_REM) && rem_hit;
  assign rem_miss = (op == OP_REM) && !rem_hit;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    if (gi == DEPTH - 1) begin : g_top
      assign nxt_addr[gi] = '0;
      assign nxt_type[gi] = '0;
    end else begin : g_mid
      assign nxt_addr[gi] = slot_addr[gi+1];
      assign nxt_type[gi] = slot_type[gi+1];
    end
    assign shift_en[gi] = rem_do && (IW'(gi) >= rem_idx);
    assign load_en[gi]  = add_ok && (wr_idx == IW'(gi));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (load_en[i]) begin
        slot_addr[i] <= wr_addr;
        slot_type[i] <= wr_type;
      end else if (shift_en[i]) begin
        slot_addr[i] <= nxt_addr[i];
        slot_type[i] <= nxt_type[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (add_ok)  count <= count + CW'(1);
    else if (rem_do)  count <= count - CW'(1);
  end

  AST_ADD_GROWS: assert property (@(posedge clk) disable iff (rst)
    add_ok |=> count == $past(count) + CW'(1)); // R2
  AST_FULL_REJECT: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD && count == CW'(DEPTH)) |=> $stable(count)); // R3
  AST_REM_SHRINK: assert property (@(posedge clk) disable iff (rst)
    rem_do |=> count == $past(count) - CW'(1)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R3
endmodule

// File: rtl/bpt_notify.sv
module bpt_notify #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xlat_en,
  input  logic          add_ok,
  input  logic          add_rej,
  input  logic          rem_do,
  input  logic          rem_miss,
  input  logic [AW-1:0] cmd_addr,
  output logic          add_err,
  output logic          rem_ok,
  output logic          rem_fail,
  output logic          inval_valid,
  output logic [AW-1:0] inval_addr
);
  logic changed;
  assign changed = add_ok || rem_do;

  always_ff @(posedge clk) begin
    if (rst) begin
      add_err     <= 1'b0;
      rem_ok      <= 1'b0;
      rem_fail    <= 1'b0;
      inval_valid <= 1'b0;
      inval_addr  <= '0;
    end else begin
      add_err     <= add_rej;
      rem_ok      <= rem_do;
      rem_fail    <= rem_miss;
      inval_valid <= changed && xlat_en;
      if (changed && xlat_en) inval_addr <= cmd_addr;
    end
  end

  AST_INVAL_GATED: assert property (@(posedge clk) disable iff (rst)
    inval_valid |-> $past(xlat_en)); // R8
  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({add_err, rem_ok, rem_fail})); // R10
endmodule

// File: rtl/bp_match_table.sv
module bp_match_table #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int TW    = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xlat_en,
  input  logic          add_req,
  input  logic          rem_req,
  input  logic [AW-1:0] cmd_addr,
  input  logic [TW-1:0] cmd_type,
  input  logic [AW-1:0] look_addr,
  output logic [TW-1:0] look_type,
  output logic          look_hit,
  output logic [CW-1:0] entry_count,
  output logic          add_err,
  output logic          rem_ok,
  output logic          rem_fail,
  output logic          inval_valid,
  output logic [AW-1:0] inval_addr
);
  import bpt_pkg::*;

  op_e                      op;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][TW-1:0] slot_type;
  logic                     rm_hit;
  logic [IW-1:0]            rm_idx;
  logic [IW-1:0]            lk_idx;
  logic                     add_ok, add_rej, rem_do, rem_miss;

  assign op = pick_op(add_req, rem_req);

  bpt_store #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) u_store (
    .clk(clk), .rst(rst), .op(op),
    .wr_addr(cmd_addr), .wr_type(cmd_type),
    .rem_hit(rm_hit), .rem_idx(rm_idx),
    .slot_addr(slot_addr), .slot_type(slot_type), .count(entry_count),
    .add_ok(add_ok), .add_rej(add_rej), .rem_do(rem_do), .rem_miss(rem_miss)
  );

  bpt_search #(.DEPTH(DEPTH), .AW(AW), .TW(TW), .USE_TYPE(1'b1)) u_rem_find (
    .slot_addr(slot_addr), .slot_type(slot_type), .count(entry_count),
    .key_addr(cmd_addr), .key_type(cmd_type), .hit(rm_hit), .idx(rm_idx)
  );

  bpt_search #(.DEPTH(DEPTH), .AW(AW), .TW(TW), .USE_TYPE(1'b0)) u_look_find (
    .slot_addr(slot_addr), .slot_type(slot_type), .count(entry_count),
    .key_addr(look_addr), .key_type('0), .hit(look_hit), .idx(lk_idx)
  );

  assign look_type = look_hit ? slot_type[lk_idx] : '0;

  bpt_notify #(.AW(AW)) u_notify (
    .clk(clk), .rst(rst), .xlat_en(xlat_en),
    .add_ok(add_ok), .add_rej(add_rej), .rem_do(rem_do), .rem_miss(rem_miss),
    .cmd_addr(cmd_addr),
    .add_err(add_err), .rem_ok(rem_ok), .rem_fail(rem_fail),
    .inval_valid(inval_valid), .inval_addr(inval_addr)
  );

  AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    rem_miss |=> rem_fail && $stable(entry_count)); // R6
  AST_ADD_WINS: assert property (@(posedge clk) disable iff (rst)
    (add_req && rem_req) |=> !rem_ok && !rem_fail); // R9
  AST_HIT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    look_hit |-> look_type != '0); // R7
endmodule

// File: tb/bp_match_table_bench.sv
module bp_match_table_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, xlat_en, add_req, rem_req;
  logic [31:0] cmd_addr, look_addr, inval_addr;
  logic [3:0]  cmd_type, look_type, entry_count;
  logic        look_hit, add_err, rem_ok, rem_fail, inval_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  bp_match_table u_bp_match_table (
    .clk(clk), .rst(rst), .xlat_en(xlat_en), .add_req(add_req), .rem_req(rem_req),
    .cmd_addr(cmd_addr), .cmd_type(cmd_type), .look_addr(look_addr),
    .look_type(look_type), .look_hit(look_hit), .entry_count(entry_count),
    .add_err(add_err), .rem_ok(rem_ok), .rem_fail(rem_fail),
    .inval_valid(inval_valid), .inval_addr(inval_addr)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 none, 1 insert, 2 delete
    logic [31:0] addr;
    logic [3:0]  typ;
    logic        xl;
    logic [3:0]  cnt;
    logic [2:0]  flg;  // {add_err, rem_ok, rem_fail}
    logic        inv;
    logic [31:0] la;
    logic [3:0]  lt;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{2'd1, 32'h100, 4'd1, 1'b1, 4'd1, 3'b000, 1'b1, 32'h100, 4'd1},
    '{2'd1, 32'h200, 4'd2, 1'b0, 4'd2, 3'b000, 1'b0, 32'h200, 4'd2},
    '{2'd1, 32'h100, 4'd3, 1'b1, 4'd3, 3'b000, 1'b1, 32'h100, 4'd1},
    '{2'd2, 32'h100, 4'd1, 1'b1, 4'd2, 3'b010, 1'b1, 32'h100, 4'd3},
    '{2'd2, 32'h200, 4'd5, 1'b1, 4'd2, 3'b001, 1'b0, 32'h200, 4'd2},
    '{2'd1, 32'h300, 4'd0, 1'b1, 4'd2, 3'b100, 1'b0, 32'h300, 4'd0},
    '{2'd2, 32'h100, 4'd3, 1'b0, 4'd1, 3'b010, 1'b0, 32'h100, 4'd0},
    '{2'd0, 32'h0,   4'd0, 1'b1, 4'd1, 3'b000, 1'b0, 32'h200, 4'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic a, input logic r, input logic [31:0] ad,
                       input logic [3:0] ty, input logic xl);
    add_req = a; rem_req = r; cmd_addr = ad; cmd_type = ty; xlat_en = xl;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] a, input logic [3:0] exp, input string tag);
    look_addr = a;
    #1;
    chk(tag, {28'd0, look_type}, {28'd0, exp});
    chk(tag, {31'd0, look_hit}, {31'd0, exp != 4'd0});
  endtask

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; xlat_en = 1'b0; add_req = 1'b0; rem_req = 1'b0;
    cmd_addr = '0; cmd_type = '0; look_addr = 32'h100;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 count", {28'd0, entry_count}, 32'd0);
    chk("R1 flags", {28'd0, add_err, rem_ok, rem_fail, inval_valid}, 32'd0);
    look(32'h100, 4'd0, "R1 lookup");

    for (int i = 0; i < 8; i++) begin
      issue(VEC[i].op == 2'd1, VEC[i].op == 2'd2, VEC[i].addr, VEC[i].typ, VEC[i].xl);
      chk("R2 R5 R6 count", {28'd0, entry_count}, {28'd0, VEC[i].cnt});
      chk("R3 R4 R5 R6 R10 flags", {29'd0, add_err, rem_ok, rem_fail}, {29'd0, VEC[i].flg});
      chk("R8 inval", {31'd0, inval_valid}, {31'd0, VEC[i].inv});
      if (VEC[i].inv) chk("R8 inval addr", inval_addr, VEC[i].addr);
      look(VEC[i].la, VEC[i].lt, "R7 lookup");
    end

    // Fill to capacity: table holds 0x200/2 then seven more.
    for (int i = 0; i < 7; i++) begin
      issue(1'b1, 1'b0, 32'h1000 + 32'(i) * 32'h10, 4'(i + 1), 1'b1);
    end
    chk("R2 full count", {28'd0, entry_count}, 32'd8);
    look(32'h1060, 4'd7, "R2 last slot");

    issue(1'b1, 1'b0, 32'h9000, 4'd5, 1'b1);
    chk("R3 add_err", {31'd0, add_err}, 32'd1);
    chk("R3 count", {28'd0, entry_count}, 32'd8);
    chk("R3 no inval", {31'd0, inval_valid}, 32'd0);
    look(32'h9000, 4'd0, "R3 not stored");

    // Middle delete: 0x1020/3 sits in slot 3.
    issue(1'b0, 1'b1, 32'h1020, 4'd3, 1'b1);
    chk("R5 rem_ok", {31'd0, rem_ok}, 32'd1);
    chk("R5 count", {28'd0, entry_count}, 32'd7);
    chk("R8 inval addr", inval_addr, 32'h1020);
    look(32'h1020, 4'd0, "R5 gone");
    look(32'h1030, 4'd4, "R5 shifted");
    look(32'h1060, 4'd7, "R5 tail");
    look(32'h1010, 4'd2, "R5 below");

    // Both strobes together: insert wins.
    issue(1'b1, 1'b1, 32'h200, 4'd2, 1'b0);
    chk("R9 count", {28'd0, entry_count}, 32'd8);
    chk("R9 rem flags", {30'd0, rem_ok, rem_fail}, 32'd0);
    look(32'h200, 4'd2, "R9 kept");

    issue(1'b0, 1'b0, 32'h0, 4'd0, 1'b0);
    chk("R10 flags drop", {28'd0, add_err, rem_ok, rem_fail, inval_valid}, 32'd0);

    // Reset after activity.
    rst = 1'b1;
    issue(1'b0, 1'b0, 32'h0, 4'd0, 1'b0);
    rst = 1'b0;
    chk("R1 count after", {28'd0, entry_count}, 32'd0);
    look(32'h200, 4'd0, "R1 lookup after");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule